// File: doc/BRIEF.md
# External Interrupt Edge/Level Conditioner

This block conditions a bank of external interrupt lines for a downstream interrupt controller. Each line first passes through a synchroniser into the block's clock domain. Software then chooses, per line, between level and edge detection and between the high/rising and low/falling sense. A detected event sets a request latch for that line. Each line drives its own active-high level output, gated by a per-line mask bit, so the controller always sees a plain high level whatever the input convention.

Software reaches the block through a small word-addressed register interface. Writes take effect on the clock edge that samples them, and reads return data combinationally from the address. Requests keep latching while a line is masked. Stale events must therefore be removed with a write-one-to-clear before a line is unmasked, or the unmask forwards them.

Top module: `extirq_conditioner`

## Requirements
- R1: After reset every mask bit reads 1, the polarity and mode registers read 0, the clear register reads 0 and every line output is 0.
- R2: A line output is high only while its request is latched and its mask bit is 0. Setting the mask bit forces the output low.
- R3: The raw status word at byte offset 0x0C shows every latched request regardless of the mask. The masked status word at 0x08 shows raw AND NOT mask.
- R4: With mode bit 1 (edge) and polarity bit 1, a 0-to-1 transition of the synchronised input sets the request. The request stays set after the input returns low, until it is cleared.
- R5: With mode bit 1 and polarity bit 0, a 1-to-0 transition sets the request, which is then held in the same way.
- R6: With mode bit 0 (level), the request equals the active level each cycle: input high for polarity 1, input low for polarity 0. A clear drops such a request for at most one cycle while the level stays active.
- R7: Writing the clear register at 0x10 clears each line whose data bit is 1 and leaves lines whose bit is 0 untouched. The clear register reads as 0.
- R8: Requests latch while a line is masked. Writing 0 to that mask bit afterwards raises the output without any new event.
- R9: When a clear write for a line and a new detected edge on that line fall in the same cycle, the request stays set.
- R10: A request appears in raw status on the third rising clock edge after the input changes: two synchroniser stages, then the request latch.
- R11: Mask at 0x00, polarity at 0x14 and mode at 0x18 read back what was written. Unmapped word addresses such as 0x04 and 0x1C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NLINES | Asynchronous external interrupt inputs |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_out | output | NLINES | Per-line active-high interrupt levels |

## Verification
Two functions can meet in one cycle: a software clear of a line's request, and a freshly detected edge on that same line. The bench arranges the collision by first latching a request on a rising-edge line. It then drops the input and raises it again, and presents the clear write in the very cycle the new edge is detected, two clock edges after the input change. The request must still read as set afterwards. A second clear with no edge present must then empty it, which shows that the surviving bit came from the edge and not from a clear that did nothing.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   // word indices (byte offset / 4) of the register map
   localparam int unsigned IDX_MASK  = 0;  // 0x00
   localparam int unsigned IDX_MSTAT = 2;  // 0x08
   localparam int unsigned IDX_RAW   = 3;  // 0x0C
   localparam int unsigned IDX_CLR   = 4;  // 0x10
   localparam int unsigned IDX_POL   = 5;  // 0x14
   localparam int unsigned IDX_MODE  = 6;  // 0x18

   typedef enum logic {
      DET_LEVEL = 1'b0,
      DET_EDGE  = 1'b1
   } det_mode_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
   import extirq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sig,        // synchronised input
   input  logic pol_hi,     // 1: high level / rising edge
   input  logic mode_edge,  // 1: edge detection
   input  logic clr,        // write-one-to-clear pulse
   output logic req
);
   logic prev_q;
   logic req_q;
   logic edge_hit;
   logic level_act;
   det_mode_e mode;

   assign mode      = mode_edge ? DET_EDGE : DET_LEVEL;
   assign edge_hit  = pol_hi ? (sig & ~prev_q) : (~sig & prev_q);
   assign level_act = ~(sig ^ pol_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         prev_q <= sig;
         unique case (mode)
            DET_EDGE:  req_q <= edge_hit | (req_q & ~clr);  // new edge beats clear
            DET_LEVEL: req_q <= level_act;
            default:   req_q <= 1'b0;
         endcase
      end
   end

   assign req = req_q;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
   import extirq_pkg::*;
#(
   parameter int unsigned NLINES = 32,
   parameter int unsigned AW     = 5,
   parameter int unsigned DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NLINES-1:0] req,
   output logic [NLINES-1:0] mask_q,
   output logic [NLINES-1:0] pol_q,
   output logic [NLINES-1:0] mode_q,
   output logic [NLINES-1:0] clr_vec,
   output logic [NLINES-1:0] irq_out
);
   localparam int unsigned IW = AW - 2;

   logic [IW-1:0]     widx;
   logic [NLINES-1:0] wbits;
   logic              unused_addr_lsb;

   assign widx            = bus_addr[AW-1:2];
   assign wbits           = bus_wdata[NLINES-1:0];
   assign unused_addr_lsb = ^bus_addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         pol_q  <= '0;
         mode_q <= '0;
      end else if (bus_wr) begin
         if (widx == IW'(IDX_MASK)) mask_q <= wbits;
         if (widx == IW'(IDX_POL))  pol_q  <= wbits;
         if (widx == IW'(IDX_MODE)) mode_q <= wbits;
      end
   end

   assign clr_vec = (bus_wr && widx == IW'(IDX_CLR)) ? wbits : '0;
   assign irq_out = req & ~mask_q;

   always_comb begin
      bus_rdata = '0;
      unique case (widx)
         IW'(IDX_MASK):  bus_rdata = DW'(mask_q);
         IW'(IDX_MSTAT): bus_rdata = DW'(req & ~mask_q);
         IW'(IDX_RAW):   bus_rdata = DW'(req);
         IW'(IDX_POL):   bus_rdata = DW'(pol_q);
         IW'(IDX_MODE):  bus_rdata = DW'(mode_q);
         default:        bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner #(
   parameter int unsigned NLINES      = 32,
   parameter int unsigned AW          = 5,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] line_in,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [NLINES-1:0] irq_out
);
   if (NLINES < 1 || NLINES > DW) begin : g_bad_lines
      $error("extirq_conditioner: NLINES must be in 1..DW");
   end
   if (AW < 5) begin : g_bad_aw
      $error("extirq_conditioner: AW must reach byte offset 0x18");
   end

   logic [NLINES-1:0] sync_q;
   logic [NLINES-1:0] req_q;
   logic [NLINES-1:0] mask_q;
   logic [NLINES-1:0] pol_q;
   logic [NLINES-1:0] mode_q;
   logic [NLINES-1:0] clr_vec;

   extirq_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_in),
      .dout (sync_q)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      extirq_detect u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .sig      (sync_q[i]),
         .pol_hi   (pol_q[i]),
         .mode_edge(mode_q[i]),
         .clr      (clr_vec[i]),
         .req      (req_q[i])
      );
   end

   extirq_regs #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .req      (req_q),
      .mask_q   (mask_q),
      .pol_q    (pol_q),
      .mode_q   (mode_q),
      .clr_vec  (clr_vec),
      .irq_out  (irq_out)
   );
endmodule

module extirq_conditioner_chk #(
   parameter int unsigned NLINES = 32,
   parameter int unsigned AW     = 5,
   parameter int unsigned DW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [AW-1:0]     bus_addr,
   input logic              bus_wr,
   input logic [DW-1:0]     bus_wdata,
   input logic [DW-1:0]     bus_rdata,
   input logic [NLINES-1:0] irq_out,
   input logic [NLINES-1:0] sync_q,
   input logic [NLINES-1:0] req_q,
   input logic [NLINES-1:0] mask_q,
   input logic [NLINES-1:0] pol_q,
   input logic [NLINES-1:0] mode_q
);
   logic [NLINES-1:0] chk_clr;
   assign chk_clr = (bus_wr && bus_addr[AW-1:2] == (AW-2)'(4)) ? bus_wdata[NLINES-1:0] : '0;

   p_reset_mask_r1: assert property (@(posedge clk) !rst_n |=> mask_q == '1);

   p_out_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~req_q) == '0);

   p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(req_q & mode_q & ~chk_clr) & ~req_q) == '0));

   p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~$past(mode_q) & (req_q ^ $past(sync_q ~^ pol_q))) == '0));

   p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[AW-1:2] == (AW-2)'(4)) |-> bus_rdata == '0);
endmodule

bind extirq_conditioner extirq_conditioner_chk #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq_out  (irq_out),
   .sync_q   (sync_q),
   .req_q    (req_q),
   .mask_q   (mask_q),
   .pol_q    (pol_q),
   .mode_q   (mode_q)
);

// File: tb/extirq_conditioner_tb.sv
module extirq_conditioner_tb;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  line_in;
   logic [4:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];
   event  smp;

   always #5 clk = ~clk;

   extirq_conditioner u_dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // monitor: pops expected items and compares with what the design shows
   initial begin
      forever begin
         @(smp);
         #1;
         while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? irq_out : bus_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      wait_edges(1);
      bus_wr = 1'b0;
   endtask

   task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      ->smp;
      #2;
   endtask

   task automatic expect_irq(input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 1; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      ->smp;
      #2;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // lines 0-3 rise-edge, 4-7 fall-edge, 8-11 level high, 12-15 level low
      line_in = 32'hFFFF_F0F0;
      wait_edges(3);
      expect_rd(5'h00, 32'hFFFF_FFFF, "R1 mask reset");
      expect_rd(5'h14, 32'h0, "R1 polarity reset");
      expect_rd(5'h18, 32'h0, "R1 mode reset");
      expect_rd(5'h10, 32'h0, "R1 clear reads zero");
      expect_irq(32'h0, "R1 outputs low");
      rst_n = 1'b1;
      wait_edges(1);
      wr(5'h14, 32'h0000_0F0F);
      wr(5'h18, 32'h0000_00FF);
      expect_rd(5'h14, 32'h0000_0F0F, "R11 polarity readback");
      expect_rd(5'h18, 32'h0000_00FF, "R11 mode readback");
      wait_edges(4);
      wr(5'h10, 32'hFFFF_FFFF);
      wait_edges(2);
      expect_rd(5'h0C, 32'h0, "R7 all cleared");

      // R10 latency and R4 rising edge on line 0
      line_in[0] = 1'b1;
      wait_edges(2);
      expect_rd(5'h0C, 32'h0, "R10 not yet after two edges");
      wait_edges(1);
      expect_rd(5'h0C, 32'h1, "R10 set on third edge");
      line_in[0] = 1'b0;
      wait_edges(4);
      expect_rd(5'h0C, 32'h1, "R4 held after input low");
      expect_irq(32'h0, "R8 masked line stays low");
      expect_rd(5'h08, 32'h0, "R3 masked status while masked");
      wr(5'h00, 32'hFFFF_FFFE);
      expect_irq(32'h1, "R8 unmask forwards stale request");
      expect_rd(5'h08, 32'h1, "R3 masked status after unmask");
      expect_rd(5'h00, 32'hFFFF_FFFE, "R11 mask readback");
      wr(5'h00, 32'hFFFF_FFFF);
      expect_irq(32'h0, "R2 mask forces output low");
      expect_rd(5'h0C, 32'h1, "R3 raw ignores mask");
      wr(5'h00, 32'hFFFF_FFFE);
      wr(5'h10, 32'h0000_0002);
      expect_rd(5'h0C, 32'h1, "R7 zero bit leaves request");
      wr(5'h10, 32'h0000_0001);
      expect_rd(5'h0C, 32'h0, "R7 one bit clears request");
      expect_irq(32'h0, "R2 output low without request");

      // R5 falling edge on line 4
      line_in[4] = 1'b0;
      wait_edges(3);
      expect_rd(5'h0C, 32'h10, "R5 falling edge latched");
      line_in[4] = 1'b1;
      wait_edges(4);
      expect_rd(5'h0C, 32'h10, "R5 held after rise");
      wr(5'h10, 32'h10);
      expect_rd(5'h0C, 32'h0, "R5 cleared");

      // R6 level high on line 8, level low on line 12
      line_in[8] = 1'b1;
      wait_edges(3);
      expect_rd(5'h0C, 32'h100, "R6 level high active");
      wr(5'h00, 32'hFFFF_FEFF);
      expect_irq(32'h100, "R2 level line forwarded high");
      wr(5'h10, 32'h100);
      wait_edges(1);
      expect_rd(5'h0C, 32'h100, "R6 clear cannot hold active level");
      line_in[8] = 1'b0;
      wait_edges(3);
      expect_rd(5'h0C, 32'h0, "R6 level high released");
      expect_irq(32'h0, "R6 output follows level");
      line_in[12] = 1'b0;
      wait_edges(3);
      expect_rd(5'h0C, 32'h1000, "R6 level low active");
      line_in[12] = 1'b1;
      wait_edges(3);
      expect_rd(5'h0C, 32'h0, "R6 level low released");

      // R9 clear and new edge in the same cycle on line 1
      line_in[1] = 1'b1;
      wait_edges(3);
      line_in[1] = 1'b0;
      wait_edges(4);
      expect_rd(5'h0C, 32'h2, "R9 request preset");
      line_in[1] = 1'b1;
      wait_edges(2);
      wr(5'h10, 32'h2);
      expect_rd(5'h0C, 32'h2, "R9 edge wins over clear");
      wr(5'h10, 32'h2);
      expect_rd(5'h0C, 32'h0, "R9 plain clear afterwards");

      // R11 unmapped addresses
      expect_rd(5'h04, 32'h0, "R11 offset 0x04 reads zero");
      expect_rd(5'h1C, 32'h0, "R11 offset 0x1C reads zero");

      wait_edges(1);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule